// File: doc/BRIEF.md
# Power Shutoff Sequencing Controller

This block moves a design with one always-on top domain and two switchable domains (A and B) between three fixed power modes. A one-cycle request carries a 2-bit mode code. The controller then steps through an ordered sequence of isolation, state save, switch-off, switch-on and state restore for domain B. It also publishes a 2-bit voltage-level request for each domain. When B is switched back on, a handshake from the power network reports that the rail is stable, and the controller waits for it before restoring state.

The sequence is held in a finite-state machine with eight states:

- `ST_IDLE`: settled in a mode.
- `ST_DN_ISO`, `ST_DN_SAVE`, `ST_DN_OFF`: the power-down path for domain B.
- `ST_UP_ON`, `ST_UP_RAIL`, `ST_UP_REST`: the power-up path for domain B.
- `ST_LVL`: a level-only change.

The transitions are:

- `ST_IDLE` → `ST_DN_ISO` when PM3 is requested from PM1 or PM2.
- `ST_IDLE` → `ST_UP_ON` when PM1 or PM2 is requested from PM3.
- `ST_IDLE` → `ST_LVL` when moving between PM1 and PM2.
- `ST_DN_ISO` → `ST_DN_SAVE` → `ST_DN_OFF` → `ST_IDLE`, each step after `WAIT_CYC` cycles.
- `ST_UP_ON` → `ST_UP_RAIL` after `WAIT_CYC` cycles.
- `ST_UP_RAIL` → `ST_UP_REST` on the first clock edge that samples `rail_ok` high.
- `ST_UP_REST` → `ST_IDLE` after `WAIT_CYC` cycles.
- `ST_LVL` → `ST_IDLE` after `WAIT_CYC` cycles.

A small clamp forces the marked enable outputs of domain B high while isolation is on.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset the controller is in PM1 (`cur_mode`=0). In this state `iso_en`=0, `restore`=1, `pwr_en`=2'b11 and `busy`=0.
- R2: Mode codes are PM1=0, PM2=1 and PM3=2. Level codes are high=3, medium=2, low=1 and off=0. The three modes map to levels as follows:
  - PM1: top high, A medium, B medium.
  - PM2: top high, A low, B low.
  - PM3: top high, A low, B off.
  The levels follow `cur_mode`, which takes the target mode on the cycle after the request is accepted.
- R3: Power-down of B begins on the cycle after acceptance. `iso_en` rises first. `restore` falls `WAIT_CYC` cycles later. `pwr_en[1]` falls a further `WAIT_CYC` cycles later. The controller returns to idle a further `WAIT_CYC` cycles after that.
- R4: Power-up of B begins on the cycle after acceptance, when `pwr_en[1]` rises. After `WAIT_CYC` cycles the controller waits for `rail_ok`, holding `restore` low while it waits. `restore` rises on the cycle after `rail_ok` is sampled high. `iso_en` falls `WAIT_CYC` cycles later, as the controller returns to idle.
- R5: While `iso_en` is 1, every bit of `b_en_out` is 1. Otherwise `b_en_out` equals `b_en_in`.
- R6: `save` is always the inverse of `restore`.
- R7: `busy` is 1 from the cycle after acceptance until the sequence ends. `done` is a single-cycle pulse on the first idle cycle after a sequence, and `busy` is 0 during that pulse.
- R8: A valid request that arrives while `busy` is high is held, and a later one replaces it. The held request is applied on the cycle after the controller returns to idle.
- R9: Request code 3 is undefined. It leaves mode, sequence and outputs unchanged, and `err` pulses on the following cycle.
- R10: A change between PM1 and PM2 keeps `iso_en`, `restore` and `pwr_en` unchanged and holds `busy` for `WAIT_CYC` cycles.
- R11: A request for the mode already in effect is ignored and does not raise `busy`.
- R12: `pwr_en[0]` stays 1 in every mode and every state, because domain A is never switched off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Mode request strobe |
| req_mode | input | 2 | Requested mode code |
| rail_ok | input | 1 | Power network reports the domain B rail is stable |
| b_en_in | input | CLAMP_W | Enable lines driven by domain B logic |
| pwr_en | output | 2 | Per-domain switch enables; bit 0 is A, bit 1 is B; low means off |
| iso_en | output | 1 | Isolation enable for domain B outputs |
| restore | output | 1 | Retention control; falling edge saves, rising edge reloads |
| save | output | 1 | Inverse of `restore` |
| lvl_top | output | 2 | Requested level for the top domain |
| lvl_a | output | 2 | Requested level for domain A |
| lvl_b | output | 2 | Requested level for domain B |
| cur_mode | output | 2 | Mode in effect or being entered |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence ends |
| err | output | 1 | One-cycle pulse for an undefined request |
| b_en_out | output | CLAMP_W | Enable lines after the isolation clamp |

## Verification
The sequencer is tried with four kinds of stimulus, and each separates a different fault:

- Level-only changes, against the down and up paths, expose a wrong choice of path.
- A power-up that holds `rail_ok` low for many cycles shows whether `restore` waits for the handshake or runs on a fixed count.
- Requests sent back to back during a sequence, including a replacement, show whether they are dropped, applied early, or applied in the wrong order.
- Undefined and same-mode requests, made both in idle and during a sequence, must leave every output untouched.

A behavioural model runs alongside the design throughout and covers the clamp, the levels and the pulse outputs on every cycle.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    // mode codes
    localparam logic [1:0] MD_PM1 = 2'd0;
    localparam logic [1:0] MD_PM2 = 2'd1;
    localparam logic [1:0] MD_PM3 = 2'd2;

    // level codes
    localparam logic [1:0] LV_OFF  = 2'd0;
    localparam logic [1:0] LV_LOW  = 2'd1;
    localparam logic [1:0] LV_MED  = 2'd2;
    localparam logic [1:0] LV_HIGH = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DN_ISO,
        ST_DN_SAVE,
        ST_DN_OFF,
        ST_UP_ON,
        ST_UP_RAIL,
        ST_UP_REST,
        ST_LVL
    } seq_state_e;

    function automatic logic mode_defined(input logic [1:0] m);
        return m != 2'd3;
    endfunction

endpackage

// File: rtl/pwr_req_hold.sv
module pwr_req_hold
    import pwr_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_mode,
    input  logic       idle,
    output logic       cand_vld,
    output logic [1:0] cand_mode,
    output logic       err
);
    logic       pend_vld;
    logic [1:0] pend_mode;
    logic       live_ok;

    assign live_ok = req_valid && mode_defined(req_mode);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_vld  <= 1'b0;
            pend_mode <= MD_PM1;
            err       <= 1'b0;
        end else begin
            err <= req_valid && !mode_defined(req_mode);
            if (live_ok && (!idle || pend_vld)) begin
                pend_vld  <= 1'b1;
                pend_mode <= req_mode;
            end else if (idle) begin
                pend_vld <= 1'b0;
            end
        end
    end

    // a held request takes priority over a live one in idle
    assign cand_vld  = idle && (pend_vld || live_ok);
    assign cand_mode = pend_vld ? pend_mode : req_mode;

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_seq_pkg::*;
#(
    parameter int WAIT_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cand_vld,
    input  logic [1:0] cand_mode,
    input  logic       rail_ok,
    output seq_state_e state,
    output logic [1:0] mode_q,
    output logic       done
);
    localparam int CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYC - 1);

    seq_state_e       nxt;
    logic [CNT_W-1:0] cnt;
    logic             step_end;

    assign step_end = (cnt == CNT_LAST);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (cand_vld && cand_mode != mode_q) begin
                    if (cand_mode == MD_PM3)    nxt = ST_DN_ISO;
                    else if (mode_q == MD_PM3)  nxt = ST_UP_ON;
                    else                        nxt = ST_LVL;
                end
            end
            ST_DN_ISO:  if (step_end) nxt = ST_DN_SAVE;
            ST_DN_SAVE: if (step_end) nxt = ST_DN_OFF;
            ST_DN_OFF:  if (step_end) nxt = ST_IDLE;
            ST_UP_ON:   if (step_end) nxt = ST_UP_RAIL;
            ST_UP_RAIL: if (rail_ok)  nxt = ST_UP_REST;
            ST_UP_REST: if (step_end) nxt = ST_IDLE;
            ST_LVL:     if (step_end) nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            mode_q <= MD_PM1;
            done   <= 1'b0;
        end else begin
            state <= nxt;
            if (nxt != state)
                cnt <= '0;
            else if (state != ST_IDLE && state != ST_UP_RAIL)
                cnt <= cnt + 1'b1;
            if (state == ST_IDLE && nxt != ST_IDLE)
                mode_q <= cand_mode;
            done <= (state != ST_IDLE) && (nxt == ST_IDLE);
        end
    end

endmodule

// File: rtl/pwr_lvl_map.sv
module pwr_lvl_map
    import pwr_seq_pkg::*;
(
    input  logic [1:0] mode,
    output logic [1:0] lvl_top,
    output logic [1:0] lvl_a,
    output logic [1:0] lvl_b
);
    always_comb begin
        lvl_top = LV_HIGH;
        unique case (mode)
            MD_PM2:  begin lvl_a = LV_LOW; lvl_b = LV_LOW; end
            MD_PM3:  begin lvl_a = LV_LOW; lvl_b = LV_OFF; end
            default: begin lvl_a = LV_MED; lvl_b = LV_MED; end
        endcase
    end
endmodule

// File: rtl/iso_clamp.sv
module iso_clamp #(
    parameter int WIDTH = 2
) (
    input  logic             iso,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign dout[i] = iso | din[i];
    end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int WAIT_CYC = 4,
    parameter int CLAMP_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [1:0]         req_mode,
    input  logic               rail_ok,
    input  logic [CLAMP_W-1:0] b_en_in,
    output logic [1:0]         pwr_en,
    output logic               iso_en,
    output logic               restore,
    output logic               save,
    output logic [1:0]         lvl_top,
    output logic [1:0]         lvl_a,
    output logic [1:0]         lvl_b,
    output logic [1:0]         cur_mode,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic [CLAMP_W-1:0] b_en_out
);
    seq_state_e state;
    logic       cand_vld;
    logic [1:0] cand_mode;
    logic [1:0] mode_q;
    logic       idle;

    assign idle = (state == ST_IDLE);

    pwr_req_hold u_req (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .idle(idle), .cand_vld(cand_vld), .cand_mode(cand_mode), .err(err)
    );

    pwr_seq_fsm #(.WAIT_CYC(WAIT_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cand_vld(cand_vld), .cand_mode(cand_mode),
        .rail_ok(rail_ok), .state(state), .mode_q(mode_q), .done(done)
    );

    pwr_lvl_map u_lvl (
        .mode(mode_q), .lvl_top(lvl_top), .lvl_a(lvl_a), .lvl_b(lvl_b)
    );

    iso_clamp #(.WIDTH(CLAMP_W)) u_clamp (
        .iso(iso_en), .din(b_en_in), .dout(b_en_out)
    );

    // output decode per state
    always_comb begin
        pwr_en[0] = 1'b1;
        unique case (state)
            ST_IDLE: begin
                iso_en    = (mode_q == MD_PM3);
                restore   = (mode_q != MD_PM3);
                pwr_en[1] = (mode_q != MD_PM3);
            end
            ST_DN_ISO:  begin iso_en = 1'b1; restore = 1'b1; pwr_en[1] = 1'b1; end
            ST_DN_SAVE: begin iso_en = 1'b1; restore = 1'b0; pwr_en[1] = 1'b1; end
            ST_DN_OFF:  begin iso_en = 1'b1; restore = 1'b0; pwr_en[1] = 1'b0; end
            ST_UP_ON:   begin iso_en = 1'b1; restore = 1'b0; pwr_en[1] = 1'b1; end
            ST_UP_RAIL: begin iso_en = 1'b1; restore = 1'b0; pwr_en[1] = 1'b1; end
            ST_UP_REST: begin iso_en = 1'b1; restore = 1'b1; pwr_en[1] = 1'b1; end
            ST_LVL:     begin iso_en = 1'b0; restore = 1'b1; pwr_en[1] = 1'b1; end
        endcase
    end

    assign save     = ~restore;
    assign busy     = ~idle;
    assign cur_mode = mode_q;

endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
    parameter int CLAMP_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [1:0]         req_mode,
    input logic               rail_ok,
    input logic [1:0]         pwr_en,
    input logic               iso_en,
    input logic               restore,
    input logic [1:0]         lvl_top,
    input logic [1:0]         cur_mode,
    input logic               busy,
    input logic               done,
    input logic               err,
    input logic [CLAMP_W-1:0] b_en_out
);
    assert_save_needs_iso_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !restore |-> iso_en);

    assert_off_isolated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en[1] |-> (iso_en && !restore));

    assert_restore_after_rail_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(restore) |-> $past(rail_ok));

    assert_clamp_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        iso_en |-> (b_en_out == {CLAMP_W{1'b1}}));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_mode_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy) |-> $stable(cur_mode));

    assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(req_valid && req_mode == 2'd3));

    assert_top_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_top == 2'd3);

    assert_a_on_R12: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_en[0]);
endmodule

bind pwr_seq_ctrl pwr_seq_chk #(.CLAMP_W(CLAMP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .rail_ok(rail_ok), .pwr_en(pwr_en), .iso_en(iso_en), .restore(restore),
    .lvl_top(lvl_top), .cur_mode(cur_mode), .busy(busy), .done(done),
    .err(err), .b_en_out(b_en_out)
);

// File: tb/sim_pwr_seq_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_seq_ctrl;
    localparam int W  = 4;
    localparam int CW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_mode = 2'd0;
    logic          rail_ok = 1'b1;
    logic [CW-1:0] b_en_in = '0;
    logic [1:0]    pwr_en, lvl_top, lvl_a, lvl_b, cur_mode;
    logic          iso_en, restore, save, busy, done, err;
    logic [CW-1:0] b_en_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    pwr_seq_ctrl #(.WAIT_CYC(W), .CLAMP_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .rail_ok(rail_ok), .b_en_in(b_en_in), .pwr_en(pwr_en), .iso_en(iso_en),
        .restore(restore), .save(save), .lvl_top(lvl_top), .lvl_a(lvl_a),
        .lvl_b(lvl_b), .cur_mode(cur_mode), .busy(busy), .done(done),
        .err(err), .b_en_out(b_en_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // behavioural reference: phase 0 idle, 1..3 down steps, 4 on, 5 rail wait, 6 restore, 7 level
    int m_ph = 0, m_tmr = 0, m_mode = 0, m_done = 0, m_err = 0;
    int m_pend[$];

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
        if (!rst_n) begin
            m_ph = 0; m_tmr = 0; m_mode = 0; m_done = 0; m_err = 0;
            m_pend.delete();
        end else begin
            automatic bit live = req_valid && req_mode != 2'd3;
            automatic int take = -1;
            m_err = (req_valid && req_mode == 2'd3) ? 1 : 0;
            m_done = 0;
            if (m_ph == 0) begin
                if (m_pend.size() > 0) begin
                    take = m_pend[0];
                    m_pend.delete();
                    if (live) m_pend.push_back(int'(req_mode));
                end else if (live) take = int'(req_mode);
                if (take >= 0 && take != m_mode) begin
                    if (take == 2) m_ph = 1;
                    else if (m_mode == 2) m_ph = 4;
                    else m_ph = 7;
                    m_mode = take;
                    m_tmr = 0;
                end
            end else begin
                if (live) begin m_pend.delete(); m_pend.push_back(int'(req_mode)); end
                if (m_ph == 5) begin
                    if (rail_ok) begin m_ph = 6; m_tmr = 0; end
                end else if (m_tmr == W - 1) begin
                    m_tmr = 0;
                    case (m_ph)
                        1: m_ph = 2;
                        2: m_ph = 3;
                        4: m_ph = 5;
                        default: begin m_ph = 0; m_done = 1; end
                    endcase
                end else m_tmr++;
            end
        end
    end

    // per-cycle comparison, after the script's negedge drives settle
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            automatic int ei, er, ep;
            automatic int la, lb;
            case (m_ph)
                0: begin ei = (m_mode == 2); er = (m_mode != 2); ep = (m_mode != 2); end
                1: begin ei = 1; er = 1; ep = 1; end
                2: begin ei = 1; er = 0; ep = 1; end
                3: begin ei = 1; er = 0; ep = 0; end
                4, 5: begin ei = 1; er = 0; ep = 1; end
                6: begin ei = 1; er = 1; ep = 1; end
                default: begin ei = 0; er = 1; ep = 1; end
            endcase
            la = (m_mode == 0) ? 2 : 1;
            lb = (m_mode == 0) ? 2 : (m_mode == 1) ? 1 : 0;
            check("R3 R4 iso_en", int'(iso_en), ei);
            check("R3 R4 restore", int'(restore), er);
            check("R3 R4 pwr_en", int'(pwr_en), 2 * ep + 1);
            check("R6 save", int'(save), 1 - er);
            check("R2 levels", int'({lvl_top, lvl_a, lvl_b}), 48 + 4 * la + lb);
            check("R2 cur_mode", int'(cur_mode), m_mode);
            check("R7 busy", int'(busy), int'(m_ph != 0));
            check("R7 done", int'(done), m_done);
            check("R9 err", int'(err), m_err);
            check("R5 clamp", int'(b_en_out), ei ? (1 << CW) - 1 : int'(b_en_in));
        end
    end

    task automatic send(input logic [1:0] md);
        req_valid = 1'b1; req_mode = md;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #3;
        check("R1 reset mode", int'(cur_mode), 0);
        check("R1 reset pwr_en", int'(pwr_en), 3);
        check("R1 reset iso/restore", int'({iso_en, restore}), 1);
        check("R1 reset busy", int'(busy), 0);
        @(negedge clk);

        // level-only change
        b_en_in = 2'b01;
        send(2'd1);
        check("R10 busy on level change", int'(busy), 1);
        check("R10 outputs unchanged", int'({iso_en, restore, pwr_en}), 7);
        wait_idle();
        check("R10 mode PM2", int'(cur_mode), 1);

        // same mode request
        send(2'd1);
        check("R11 no busy", int'(busy), 0);

        // undefined code in idle
        send(2'd3);
        check("R9 err pulse", int'(err), 1);
        check("R9 mode kept", int'(cur_mode), 1);
        check("R9 no busy", int'(busy), 0);

        // power-down of B
        b_en_in = 2'b00;
        send(2'd2);
        check("R3 iso first", int'({iso_en, restore, pwr_en[1]}), 7);
        send(2'd3);
        check("R9 err while busy", int'(err), 1);
        wait_idle();
        check("R3 B off", int'(pwr_en), 1);
        check("R12 A on", int'(pwr_en[0]), 1);
        check("R5 clamp in PM3", int'(b_en_out), 3);

        // power-up with slow rail
        rail_ok = 1'b0;
        send(2'd0);
        repeat (3 * W + 5) @(negedge clk);
        check("R4 waits for rail", int'({busy, restore}), 2);
        rail_ok = 1'b1;
        wait_idle();
        check("R4 up done", int'({iso_en, restore, cur_mode}), 4);

        // queued requests: latest wins
        b_en_in = 2'b10;
        send(2'd2);
        send(2'd1);
        send(2'd0);
        wait_idle();
        check("R8 hold done", int'(done), 1);
        @(negedge clk);
        check("R8 pending applied", int'({busy, cur_mode}), 4);
        wait_idle();
        check("R8 final mode", int'(cur_mode), 0);
        check("R8 restore high", int'(restore), 1);

        // back-to-back with ignored same-mode while busy
        send(2'd2);
        send(2'd2);
        wait_idle();
        @(negedge clk);
        check("R11 no extra run", int'(busy), 0);
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule